// File: doc/BRIEF.md
# Calibrated ADC Code to Millivolt Converter

This block takes one raw converter code together with the channel it was sampled on and that channel's scale setting, and returns the input voltage in millivolts. The code is first mapped onto a straight line through two known points. Channel 5 uses a wide-range line (4200 mV and 3600 mV). Every other channel uses a narrow-range line (1000 mV and 100 mV). Channels 1 and 5 return the line value as it stands. All remaining channels divide it back through the attenuation ratio of their input network, with rounding to nearest.

The code endpoints of each line start at fixed uncalibrated values. A calibration word, written through a separate port, replaces them with trimmed values. A request is taken on a valid/ready handshake. The block then runs one or two passes of a shared serial divider and presents the result with a one-cycle output strobe. The calibration in effect at the moment a request is accepted applies to that request.

Top module: `adc_mv_conv`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, and the uncalibrated endpoints apply. These are codes 3413/341 for the narrow line and 3310/2832 for the wide line, paired with the high and low voltage respectively.
- R2: A request is taken in a cycle where in_valid and in_ready are both 1. in_ready then stays 0 until the result has been presented. out_valid is high for exactly one cycle per request, and in_ready returns to 1 in the cycle after it.
- R3: Channel 5 returns (4200−3600)×(code−a1)/(a0−a1)+3600 from the wide line, where a0 and a1 are its high and low endpoint codes.
- R4: Channel 1 returns (1000−100)×(code−a1)/(a0−a1)+100 from the narrow line.
- R5: A calibration write with cal_sel=1 targets the wide line and cal_sel=0 the narrow line. Bits [7:0] of the word set the high endpoint and bits [15:8] the low endpoint. Each endpoint becomes (byte + nominal − 128)×4, with nominals 856/733 (wide) and 833/80 (narrow). The new endpoints apply to requests accepted after the write, and not to a request already accepted.
- R6: The interpolation quotient truncates toward zero, and a negative line value is clamped to 0.
- R7: For channels other than 1 and 5, the narrow-line value V becomes (V×den + num/2)/num, truncated. The ratio num/den is 375/9000 on channel 6 and 1/3 on channel 19. It is 400/1025 on channels 2–4 and 100/125 on channels 7–8 when the scale is nonzero. Every other channel uses 1/1.
- R8: On channels 2–4 and 7–8, a scale value of zero selects the ratio 1/1.
- R9: A result above 65535 is presented as 65535.
- R10: If a line's two endpoint codes are equal, the interpolation term is 0 and the result equals that line's low voltage.
- R11: in_valid asserted while a request is in progress is ignored: it starts no conversion and produces no extra result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_we | input | 1 | Calibration word write strobe |
| cal_sel | input | 1 | Line selected by the write: 1 wide, 0 narrow |
| cal_word | input | 16 | Calibration bytes: [7:0] high endpoint, [15:8] low endpoint |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to take a request |
| in_code | input | 12 | Raw converter code |
| in_chan | input | 5 | Channel number |
| in_scale | input | 3 | Channel scale setting (zero or nonzero matters) |
| out_valid | output | 1 | One-cycle result strobe |
| out_mv | output | 16 | Result in millivolts |

## Verification
The bench builds the block with its default widths: 12-bit codes, 5-bit channels, 16-bit output and a 32-bit divider. The 32-bit divider leaves room for extreme calibration bytes. These bring within reach a zero-span wide line, a four-code span that overflows the 16-bit output, and a narrow line trimmed so that low codes fall below zero. A calibration write issued while a request is still in flight shows that the earlier request keeps its old endpoints.

// File: rtl/adc_mv_pkg.sv
`timescale 1ns/1ps
package adc_mv_pkg;

   localparam int CH_WIDE   = 5;
   localparam int CH_NARROW = 1;

   typedef struct packed {
      logic [15:0] num;
      logic [15:0] den;
   } ratio_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD1,
      ST_WAIT1,
      ST_LOAD2,
      ST_WAIT2,
      ST_OUT
   } stage_t;

   // line constants: wide = 1, narrow = 0
   function automatic int volt_hi(input logic wide);
      return wide ? 4200 : 1000;
   endfunction

   function automatic int volt_lo(input logic wide);
      return wide ? 3600 : 100;
   endfunction

   function automatic int rst_code_hi(input logic wide);
      return wide ? 3310 : 3413;
   endfunction

   function automatic int rst_code_lo(input logic wide);
      return wide ? 2832 : 341;
   endfunction

   function automatic int nom_code_hi(input logic wide);
      return wide ? 856 : 833;
   endfunction

   function automatic int nom_code_lo(input logic wide);
      return wide ? 733 : 80;
   endfunction

   function automatic ratio_t chan_ratio(input int ch, input logic scale_nz);
      ratio_t r;
      r.num = 16'd1;
      r.den = 16'd1;
      case (ch)
         2, 3, 4: if (scale_nz) begin r.num = 16'd400; r.den = 16'd1025; end
         6:       begin r.num = 16'd375; r.den = 16'd9000; end
         7, 8:    if (scale_nz) begin r.num = 16'd100; r.den = 16'd125; end
         19:      begin r.num = 16'd1; r.den = 16'd3; end
         default: ;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/adc_mv_cal.sv
`timescale 1ns/1ps
module adc_mv_cal
   import adc_mv_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cal_we,
   input  logic             cal_sel,
   input  logic [15:0]      cal_word,
   output logic [1:0][15:0] ep_hi,
   output logic [1:0][15:0] ep_lo
);

   function automatic logic [15:0] trim_code(input logic [7:0] b, input int nom);
      int t;
      t = (int'(b) + nom - 128) * 4;
      return t[15:0];
   endfunction

   for (genvar g = 0; g < 2; g++) begin : g_line
      localparam logic WIDE = (g == 1);
      logic [15:0] hi_q, lo_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hi_q <= 16'(rst_code_hi(WIDE));
            lo_q <= 16'(rst_code_lo(WIDE));
         end else if (cal_we && (cal_sel == WIDE)) begin
            hi_q <= trim_code(cal_word[7:0],  nom_code_hi(WIDE));
            lo_q <= trim_code(cal_word[15:8], nom_code_lo(WIDE));
         end
      end

      assign ep_hi[g] = hi_q;
      assign ep_lo[g] = lo_q;
   end

endmodule

// File: rtl/adc_mv_div.sv
`timescale 1ns/1ps
module adc_mv_div #(
   parameter int W          = 32,
   parameter bit SIGNED_OPS = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic signed [W-1:0] dvd,
   input  logic signed [W-1:0] dvs,
   output logic                done,
   output logic signed [W-1:0] quot
);

   localparam int CNT_W = $clog2(W + 1);

   if (W < 4) begin : g_w_check
      $error("adc_mv_div: W too small");
   end

   logic [W-1:0]     mag_n, mag_d;
   logic             neg_d;
   logic [W-1:0]     q_q, r_q, d_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q, done_q, neg_q, zero_q;
   logic [W:0]       trial, diff;

   if (SIGNED_OPS) begin : g_signed
      assign mag_n = dvd[W-1] ? W'(-dvd) : W'(dvd);
      assign mag_d = dvs[W-1] ? W'(-dvs) : W'(dvs);
      assign neg_d = dvd[W-1] ^ dvs[W-1];
   end else begin : g_unsigned
      assign mag_n = W'(dvd);
      assign mag_d = W'(dvs);
      assign neg_d = 1'b0;
   end

   assign trial = {r_q, q_q[W-1]};
   assign diff  = trial - {1'b0, d_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_q    <= '0;
         r_q    <= '0;
         d_q    <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         neg_q  <= 1'b0;
         zero_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start && !busy_q) begin
            q_q    <= mag_n;
            r_q    <= '0;
            d_q    <= mag_d;
            neg_q  <= neg_d;
            zero_q <= (mag_d == '0);
            cnt_q  <= CNT_W'(W);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            if (!diff[W]) begin
               r_q <= diff[W-1:0];
               q_q <= {q_q[W-2:0], 1'b1};
            end else begin
               r_q <= trial[W-1:0];
               q_q <= {q_q[W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done = done_q;
   assign quot = zero_q ? '0 : (neg_q ? $signed(-q_q) : $signed(q_q));

endmodule

// File: rtl/adc_mv_conv.sv
`timescale 1ns/1ps
module adc_mv_conv
   import adc_mv_pkg::*;
#(
   parameter int CODE_W  = 12,
   parameter int CHAN_W  = 5,
   parameter int SCALE_W = 3,
   parameter int OUT_W   = 16,
   parameter int DIV_W   = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cal_we,
   input  logic               cal_sel,
   input  logic [15:0]        cal_word,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [CODE_W-1:0]  in_code,
   input  logic [CHAN_W-1:0]  in_chan,
   input  logic [SCALE_W-1:0] in_scale,
   output logic               out_valid,
   output logic [OUT_W-1:0]   out_mv
);

   localparam logic signed [DIV_W-1:0] OUT_MAX = DIV_W'((64'd1 << OUT_W) - 64'd1);

   if (DIV_W < 32)            begin : g_chk_div  $error("adc_mv_conv: DIV_W below 32"); end
   if (CHAN_W < 5)            begin : g_chk_chan $error("adc_mv_conv: CHAN_W cannot hold channel 19"); end
   if (OUT_W > DIV_W - 2)     begin : g_chk_out  $error("adc_mv_conv: OUT_W too wide"); end
   if (CODE_W > DIV_W - 16)   begin : g_chk_code $error("adc_mv_conv: CODE_W too wide"); end
   if (SCALE_W < 1)           begin : g_chk_scl  $error("adc_mv_conv: SCALE_W below 1"); end

   // calibration storage
   logic [1:0][15:0] ep_hi, ep_lo;

   adc_mv_cal i_cal (
      .clk      (clk),
      .rst_n    (rst_n),
      .cal_we   (cal_we),
      .cal_sel  (cal_sel),
      .cal_word (cal_word),
      .ep_hi    (ep_hi),
      .ep_lo    (ep_lo)
   );

   // request decode
   stage_t st_q;
   logic   accept;
   logic   wide_d, direct_d;
   logic signed [DIV_W-1:0] a0_x, a1_x, raw_x, vspan_x, vlo_x;
   logic signed [DIV_W-1:0] dvd1_d, dvs1_d;

   assign in_ready = (st_q == ST_IDLE);
   assign accept   = in_valid && in_ready;

   assign wide_d   = (in_chan == CHAN_W'(CH_WIDE));
   assign direct_d = wide_d || (in_chan == CHAN_W'(CH_NARROW));
   assign a0_x     = DIV_W'($signed(ep_hi[wide_d]));
   assign a1_x     = DIV_W'($signed(ep_lo[wide_d]));
   assign raw_x    = DIV_W'(in_code);
   assign vspan_x  = DIV_W'(volt_hi(wide_d) - volt_lo(wide_d));
   assign vlo_x    = DIV_W'(volt_lo(wide_d));
   assign dvd1_d   = vspan_x * (raw_x - a1_x);
   assign dvs1_d   = a0_x - a1_x;

   // shared divider
   logic signed [DIV_W-1:0] dvd_q, dvs_q, div_q;
   logic                    div_start, div_done;

   assign div_start = (st_q == ST_LOAD1) || (st_q == ST_LOAD2);

   adc_mv_div #(.W(DIV_W), .SIGNED_OPS(1'b1)) i_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (div_start),
      .dvd   (dvd_q),
      .dvs   (dvs_q),
      .done  (div_done),
      .quot  (div_q)
   );

   // post-interpolation
   logic signed [DIV_W-1:0] v1_q, v_sum, v_clamp, num_x, den_x, dvd2_d;
   logic                    direct_q;
   ratio_t                  ratio_q;
   logic [OUT_W-1:0]        res_q;

   assign v_sum   = div_q + v1_q;
   assign v_clamp = v_sum[DIV_W-1] ? '0 : v_sum;
   assign num_x   = DIV_W'(ratio_q.num);
   assign den_x   = DIV_W'(ratio_q.den);
   assign dvd2_d  = v_clamp * den_x + (num_x >>> 1);

   function automatic logic [OUT_W-1:0] sat(input logic signed [DIV_W-1:0] x);
      if (x < 0)            return '0;
      else if (x > OUT_MAX) return OUT_MAX[OUT_W-1:0];
      else                  return x[OUT_W-1:0];
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         dvd_q    <= '0;
         dvs_q    <= '0;
         v1_q     <= '0;
         direct_q <= 1'b0;
         ratio_q  <= '0;
         res_q    <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (accept) begin
               dvd_q    <= dvd1_d;
               dvs_q    <= dvs1_d;
               v1_q     <= vlo_x;
               direct_q <= direct_d;
               ratio_q  <= chan_ratio(int'(in_chan), |in_scale);
               st_q     <= ST_LOAD1;
            end
            ST_LOAD1: st_q <= ST_WAIT1;
            ST_WAIT1: if (div_done) begin
               if (direct_q) begin
                  res_q <= sat(v_clamp);
                  st_q  <= ST_OUT;
               end else begin
                  dvd_q <= dvd2_d;
                  dvs_q <= num_x;
                  st_q  <= ST_LOAD2;
               end
            end
            ST_LOAD2: st_q <= ST_WAIT2;
            ST_WAIT2: if (div_done) begin
               res_q <= sat(div_q);
               st_q  <= ST_OUT;
            end
            ST_OUT:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign out_valid = (st_q == ST_OUT);
   assign out_mv    = res_q;

endmodule

// File: rtl/adc_mv_chk.sv
`timescale 1ns/1ps
module adc_mv_chk (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic out_valid
);

   logic [1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else if (in_valid && in_ready && !out_valid) pend_q <= pend_q + 2'd1;
      else if (out_valid && !(in_valid && in_ready)) pend_q <= pend_q - 2'd1;
   end

   p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   p_ready_after_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> in_ready);

   p_one_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (pend_q == 2'd1));

   p_no_take_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q != 2'd0) |-> !in_ready);

endmodule

bind adc_mv_conv adc_mv_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid)
);

// File: tb/test_adc_mv_conv.sv
`timescale 1ns/1ps
module test_adc_mv_conv;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cal_we = 1'b0;
   logic        cal_sel = 1'b0;
   logic [15:0] cal_word = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [11:0] in_code = '0;
   logic [4:0]  in_chan = '0;
   logic [2:0]  in_scale = '0;
   logic        out_valid;
   logic [15:0] out_mv;

   always #5 clk = ~clk;

   adc_mv_conv #(.CODE_W(12), .CHAN_W(5), .SCALE_W(3), .OUT_W(16), .DIV_W(32)) i_adc_mv_conv (
      .clk, .rst_n, .cal_we, .cal_sel, .cal_word,
      .in_valid, .in_ready, .in_code, .in_chan, .in_scale,
      .out_valid, .out_mv
   );

   int    total = 0, bad = 0, n_out = 0, n_req = 0;
   bit    finished = 0;
   longint exp_q[$];
   string  tag_q[$];
   // index 0 narrow line, 1 wide line
   longint m_hi[2] = '{3413, 3310};
   longint m_lo[2] = '{341, 2832};

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint model(input int ch, input int sc, input int code);
      int     w;
      longint vh, vl, span, t, v, num, den, r;
      w  = (ch == 5) ? 1 : 0;
      vh = w ? 4200 : 1000;
      vl = w ? 3600 : 100;
      span = m_hi[w] - m_lo[w];
      t = (span == 0) ? 0 : ((vh - vl) * (code - m_lo[w])) / span;
      v = t + vl;
      if (v < 0) v = 0;
      if (ch == 1 || ch == 5) r = v;
      else begin
         num = 1; den = 1;
         if ((ch >= 2 && ch <= 4) && sc != 0) begin num = 400; den = 1025; end
         if (ch == 6) begin num = 375; den = 9000; end
         if ((ch == 7 || ch == 8) && sc != 0) begin num = 100; den = 125; end
         if (ch == 19) begin num = 1; den = 3; end
         r = (v * den + num / 2) / num;
      end
      if (r > 65535) r = 65535;
      return r;
   endfunction

   // monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         n_out++;
         if (exp_q.size() == 0) check(1'b0, "R11 unexpected result", out_mv, -1);
         else begin
            longint e;
            string  t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(longint'(out_mv) == e, t, out_mv, e);
         end
      end
   end

   task automatic convert(input int ch, input int sc, input int code, input string tag);
      exp_q.push_back(model(ch, sc, code));
      tag_q.push_back(tag);
      n_req++;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_chan  = 5'(ch);
      in_scale = 3'(sc);
      in_code  = 12'(code);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic cal_write(input bit sel, input logic [15:0] w);
      int s;
      s = sel ? 1 : 0;
      m_hi[s] = (longint'(w[7:0])  + (sel ? 856 : 833) - 128) * 4;
      m_lo[s] = (longint'(w[15:8]) + (sel ? 733 : 80)  - 128) * 4;
      @(negedge clk);
      cal_we = 1'b1; cal_sel = sel; cal_word = w;
      @(negedge clk);
      cal_we = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #1_500_000;
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", n_out, n_req);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
      check(out_valid == 1'b0, "R1 no strobe after reset", out_valid, 0);

      // uncalibrated lines
      convert(1, 0, 341,  "R1 R4 narrow low point");
      convert(1, 0, 3413, "R4 narrow high point");
      convert(1, 0, 0,    "R6 truncation toward zero");
      convert(5, 0, 3310, "R1 R3 wide high point");
      convert(5, 0, 2832, "R3 wide low point");
      convert(5, 0, 0,    "R3 wide below range");
      // ratios
      convert(2, 1, 3413, "R7 ch2 scaled");
      convert(2, 0, 3413, "R8 ch2 scale zero");
      convert(7, 2, 3413, "R7 ch7 scaled");
      convert(8, 0, 3413, "R8 ch8 scale zero");
      convert(6, 0, 3413, "R7 ch6 ratio");
      convert(6, 0, 0,    "R7 ch6 rounding");
      convert(19, 0, 341, "R7 ch19 ratio");
      convert(0, 5, 2000, "R7 ch0 unity");
      convert(31, 0, 4095, "R7 ch31 unity");
      drain();

      // R11: requests while busy are ignored
      convert(1, 0, 1000, "R11 single result");
      in_valid = 1'b1; in_chan = 5'd5; in_code = 12'd4000;
      for (int i = 0; i < 6; i++) begin
         check(in_ready == 1'b0, "R2 R11 busy holds ready low", in_ready, 0);
         @(negedge clk);
      end
      in_valid = 1'b0;
      drain();

      // calibration
      cal_write(1'b0, 16'hFF00);
      convert(1, 0, 0,   "R6 clamp negative to zero");
      convert(1, 0, 828, "R5 narrow trimmed low");
      drain();
      cal_write(1'b0, 16'h8080);
      convert(1, 0, 3332, "R5 narrow trimmed high");
      convert(3, 1, 3332, "R5 R7 trimmed ratio");
      cal_write(1'b1, 16'h7B00);
      convert(5, 0, 1000, "R10 zero span");
      cal_write(1'b1, 16'h7A00);
      convert(5, 0, 4095, "R9 saturate");
      // write lands while this request is in flight
      cal_write(1'b1, 16'h8080);
      convert(5, 0, 3424, "R5 wide trimmed high");
      cal_write(1'b1, 16'h7B00);
      drain();
      convert(5, 0, 2000, "R10 zero span again");
      drain();

      repeat (100) @(negedge clk);
      check(n_out == n_req, "R2 R11 result count", n_out, n_req);
      check(in_ready == 1'b1, "R2 idle at end", in_ready, 1);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule